// File: doc/BRIEF.md
# Vectored Interrupt Request Port

This block sits on the peripheral side of a vectored interrupt scheme. When the peripheral captures a new input word into its data register, it raises an interrupt request toward the processor. The processor samples that request only between instructions. When it answers with an interrupt-acknowledge, the block places a vector on the shared data bus and asserts an output-enable for as long as the acknowledge is held.

The vector comes from a vector register that can be written through a small configuration write port. A mode bit selects between two readings of that register. In direct mode the whole register is driven as a full service-routine address. In table mode only its low index bits are driven, zero-extended, as an entry number into an interrupt address table.

The acknowledge does not withdraw the request. The request stays up until the service routine reads the data register. If a second word arrives before that read, the older word is overwritten and an overrun flag is raised.

Top module: `vec_irq_port`

## Requirements
- R1: After reset, `irq` and `overrun` are 0, `bus_oe` is 0, `bus_data` is 0, `rd_data` is 0, the vector register holds 0 and the mode is direct (0).
- R2: A cycle with `in_load` high stores `in_data`. From the next clock edge, `rd_data` shows that word and `irq` is 1.
- R3: While `inta` is high in direct mode (mode 0), `bus_oe` is 1 and `bus_data` equals the full vector register.
- R4: While `inta` is high in table mode (mode 1), `bus_data` carries the low IDXW bits of the vector register, with all higher bits 0.
- R5: While `inta` is low, `bus_oe` is 0 and `bus_data` is 0.
- R6: An acknowledge does not clear `irq`. A pending request stays 1 through and after `inta` until a data read occurs.
- R7: A cycle with `rd_en` high and `in_load` low clears both `irq` and `overrun` at the next edge. `rd_data` keeps the stored word.
- R8: A load while `irq` is already 1 (and no read in that cycle) sets `overrun` at the next edge and replaces the stored word with the new one.
- R9: A load and a read in the same cycle leave `irq` at 1, store the new word, and clear `overrun` rather than set it.
- R10: A configuration write with `cfg_sel` = 0 loads `cfg_wdata` into the vector register. One with `cfg_sel` = 1 loads `cfg_wdata[0]` into the mode bit and leaves the vector unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_load | input | 1 | Capture `in_data` into the data register |
| in_data | input | DW | New input word from the peripheral side |
| rd_en | input | 1 | Processor read of the data register |
| rd_data | output | DW | Current contents of the data register |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0: vector register, 1: mode bit |
| cfg_wdata | input | DW | Configuration write data |
| inta | input | 1 | Interrupt acknowledge from the processor |
| irq | output | 1 | Interrupt request |
| overrun | output | 1 | Data was overwritten before being read |
| bus_data | output | DW | Vector driven during acknowledge, 0 otherwise |
| bus_oe | output | 1 | Bus output-enable, high only during acknowledge |

## Verification
A request flag that is cleared by the acknowledge instead of the read would show as `irq` at 0 in the cycle after `inta` while the word is still unread. A lost overrun update would show as a missing `overrun` one edge after the second load. A wrong mode or vector state becomes visible at once on `bus_data` when `inta` next rises, because the vector path has no register stage. The bench drives the processor side with a model that issues acknowledges and reads only at instruction boundaries. It also covers the coincident load-and-read case, where only the ordering of the request and overrun updates separates a correct design from a faulty one.

// File: rtl/vec_irq_port.sv
module vec_irq_port #(
  parameter int DW   = 8,
  parameter int IDXW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_load,
  input  logic [DW-1:0] in_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  input  logic          cfg_we,
  input  logic          cfg_sel,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          inta,
  output logic          irq,
  output logic          overrun,
  output logic [DW-1:0] bus_data,
  output logic          bus_oe
);

  localparam int PADW = DW - IDXW;

  logic [DW-1:0] data_q;
  logic [DW-1:0] vec_q;
  logic          mode_q;
  logic          irq_q;
  logic          ovr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      irq_q  <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (in_load) data_q <= in_data;
      if (in_load) irq_q <= 1'b1;
      else if (rd_en) irq_q <= 1'b0;
      if (rd_en) ovr_q <= 1'b0;
      else if (in_load && irq_q) ovr_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q  <= '0;
      mode_q <= 1'b0;
    end else if (cfg_we) begin
      if (cfg_sel) mode_q <= cfg_wdata[0];
      else         vec_q  <= cfg_wdata;
    end
  end

  logic [DW-1:0] vec_out;
  assign vec_out  = mode_q ? {{PADW{1'b0}}, vec_q[IDXW-1:0]} : vec_q;
  assign bus_oe   = inta;
  assign bus_data = inta ? vec_out : '0;
  assign rd_data  = data_q;
  assign irq      = irq_q;
  assign overrun  = ovr_q;

  // R2
  load_raises_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_load |=> (irq && rd_data == $past(in_data)));

  // R6
  ack_keeps_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && inta && !rd_en) |=> irq);

  // R7
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !in_load) |=> (!irq && !overrun));

  // R8
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_load && irq && !rd_en) |=> overrun);

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ($stable(vec_q) && $stable(mode_q)));

endmodule

// File: tb/vec_irq_port_bench.sv
module vec_irq_port_bench;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_load = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          rd_en = 1'b0;
  logic [DW-1:0] rd_data;
  logic          cfg_we = 1'b0;
  logic          cfg_sel = 1'b0;
  logic [DW-1:0] cfg_wdata = '0;
  logic          inta = 1'b0;
  logic          irq, overrun, bus_oe;
  logic [DW-1:0] bus_data;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  vec_irq_port #(.DW(DW), .IDXW(4)) u_vec_irq_port (
    .clk(clk), .rst_n(rst_n), .in_load(in_load), .in_data(in_data),
    .rd_en(rd_en), .rd_data(rd_data), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .inta(inta), .irq(irq), .overrun(overrun),
    .bus_data(bus_data), .bus_oe(bus_oe)
  );

  // {load, data[8], rd, inta, e_irq, e_ovr, e_oe, e_bus[8], e_rd[8]}
  localparam int NV = 9;
  localparam logic [29:0] TBL [0:NV-1] = '{
    {1'b1, 8'h11, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h11}, // R2
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'hA5, 8'h11}, // R3 R6
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h11}, // R5 R6
    {1'b1, 8'h22, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h22}, // R8
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h22}, // R7
    {1'b1, 8'h33, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h33}, // R2
    {1'b1, 8'h44, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h44}, // R9
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h44}, // R7
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'hA5, 8'h44}  // R3
  };

  task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // processor-side step: inputs change at the instruction boundary (negedge)
  task automatic step(input logic ld, input logic [DW-1:0] d, input logic rd, input logic ack);
    @(negedge clk);
    in_load = ld; in_data = d; rd_en = rd; inta = ack;
    @(posedge clk); #1;
  endtask

  task automatic cfg(input logic sel, input logic [DW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 irq", {7'd0, irq}, 8'd0);
    chk("R1 overrun", {7'd0, overrun}, 8'd0);
    chk("R1 bus_oe", {7'd0, bus_oe}, 8'd0);
    chk("R1 rd_data", rd_data, 8'd0);
    @(negedge clk); rst_n = 1'b1;
    step(1'b0, 8'h00, 1'b0, 1'b1);
    chk("R1 reset vector", bus_data, 8'h00);
    step(1'b0, 8'h00, 1'b0, 1'b0);

    cfg(1'b0, 8'hA5); // R10
    for (int i = 0; i < NV; i++) begin
      logic [29:0] v;
      v = TBL[i];
      step(v[29], v[28:21], v[20], v[19]);
      chk($sformatf("vec%0d irq", i), {7'd0, irq}, {7'd0, v[18]});
      chk($sformatf("vec%0d overrun", i), {7'd0, overrun}, {7'd0, v[17]});
      chk($sformatf("vec%0d bus_oe", i), {7'd0, bus_oe}, {7'd0, v[16]});
      chk($sformatf("vec%0d bus_data", i), bus_data, v[15:8]);
      chk($sformatf("vec%0d rd_data", i), rd_data, v[7:0]);
    end
    step(1'b0, 8'h00, 1'b0, 1'b0);

    // R4: table mode drives low index bits only
    cfg(1'b1, 8'h01);
    step(1'b0, 8'h00, 1'b0, 1'b1);
    chk("R4 table index", bus_data, 8'h05);
    // R10: vector write in table mode, mode unchanged
    cfg(1'b0, 8'h3C);
    step(1'b0, 8'h00, 1'b0, 1'b1);
    chk("R10 R4 new vector index", bus_data, 8'h0C);
    // R10: mode write leaves vector intact
    cfg(1'b1, 8'hFE);
    step(1'b0, 8'h00, 1'b0, 1'b1);
    chk("R10 R3 mode write keeps vector", bus_data, 8'h3C);
    step(1'b0, 8'h00, 1'b0, 1'b0);
    chk("R5 idle bus", bus_data, 8'h00);

    // R6: long acknowledge with pending request, then R7 read
    step(1'b1, 8'h5A, 1'b0, 1'b0);
    step(1'b0, 8'h00, 1'b0, 1'b1);
    step(1'b0, 8'h00, 1'b0, 1'b1);
    chk("R6 irq held over ack", {7'd0, irq}, 8'd1);
    step(1'b0, 8'h00, 1'b1, 1'b0);
    chk("R7 read clears irq", {7'd0, irq}, 8'd0);
    chk("R7 data kept", rd_data, 8'h5A);

    // R9: overrun pending then load+read clears overrun
    step(1'b1, 8'h61, 1'b0, 1'b0);
    step(1'b1, 8'h62, 1'b0, 1'b0);
    chk("R8 overrun set", {7'd0, overrun}, 8'd1);
    step(1'b1, 8'h63, 1'b1, 1'b0);
    chk("R9 overrun cleared", {7'd0, overrun}, 8'd0);
    chk("R9 irq stays", {7'd0, irq}, 8'd1);
    chk("R9 new data", rd_data, 8'h63);

    // R1: reset while pending
    @(negedge clk); in_load = 1'b0; rst_n = 1'b0;
    #1;
    chk("R1 reset clears irq", {7'd0, irq}, 8'd0);
    chk("R1 reset clears data", rd_data, 8'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule